// File: doc/BRIEF.md
# Pointer-Addressed Register Access Controller

This block sits behind the byte layer of a two-wire serial slave port. It turns a stream of received and requested bytes into accesses to a small bank of three 8-bit registers: an interrupt-enable register, a control register and a read-only interrupt-status register. The registers themselves live outside this block. It drives their write enables and shared write data, and it takes their current values in for read-back.

After each START and address match, the serial engine pulses `start_i`. The next received byte is a command byte. Its two low bits form the register pointer, and its bit 2 enables auto-increment. Each later received byte is a data write to the pointed register, and each byte requested by the master returns the pointed register. When auto-increment is enabled, the pointer steps forward after every data byte. It stops at the status register and never returns to the first register. The block answers each received byte with an acknowledge or a refusal, which the serial engine then drives onto the bus.

All outputs are registered. Each one answers a strobe in the clock cycle that follows it.

Top module: `regacc_core`

## Requirements
- R1: After reset, the pointer is 00, auto-increment is off, the next received byte is treated as a command, and all strobe outputs are low. A read before any command returns the interrupt-enable register.
- R2: The first byte received after `start_i` is stored as the command byte. It is acknowledged (`ack_vld_o`=1 and `ack_o`=1 in the next cycle) and raises no write enable.
- R3: Pointer bits [1:0] of the command select the target: 00 is interrupt enable, 01 is control, 10 is interrupt status.
- R4: A data byte aimed at pointer 00 or 01 is acknowledged. In the next cycle it pulses `ie_we_o` or `ctrl_we_o` respectively, with the byte on `wdata_o`. At most one write enable is high in any cycle.
- R5: A data byte aimed at pointer 10 is refused (`ack_vld_o`=1, `ack_o`=0) and raises no write enable.
- R6: When command bit 2 is 1, the pointer advances by one after each data byte received or sent. It saturates at 10. A command of 0x04 followed by three data bytes therefore acknowledges the first two bytes (interrupt enable, then control) and refuses the third.
- R7: When command bit 2 is 0, the pointer holds its value across any number of data bytes.
- R8: Pointer 11 is an invalid target. Writes to it are refused, reads return 0x00, and auto-increment leaves it at 11.
- R9: A `start_i` pulse part-way through a transfer makes the next received byte a command again.
- R10: A byte request returns the pointed register on `rd_data_o`, with `rd_vld_o` high, in the next cycle. The value is taken before any auto-increment step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse: START plus address match seen |
| wr_vld_i | input | 1 | Pulse: a byte has been received |
| wr_data_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Pulse: the master requests a byte |
| ie_q_i | input | 8 | Current interrupt-enable register value |
| ctrl_q_i | input | 8 | Current control register value |
| stat_q_i | input | 8 | Current interrupt-status register value |
| ack_vld_o | output | 1 | Acknowledge decision is valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| ie_we_o | output | 1 | Write enable for the interrupt-enable register |
| ctrl_we_o | output | 1 | Write enable for the control register |
| wdata_o | output | 8 | Write data for the register bank |
| rd_vld_o | output | 1 | Read data is valid |
| rd_data_o | output | 8 | Byte to send to the master |

## Verification
The assertions assume that the serial engine raises at most one of `start_i`, `wr_vld_i` and `rd_req_i` in a given cycle. They also assume that each strobe lasts exactly one cycle, since a byte takes many clocks on the wire. The directed tasks drive every strobe for one cycle on the falling clock edge, with at least one idle cycle between strobes. The register values are held steady while a read is in progress.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
  localparam int unsigned PTR_W    = 2;
  localparam int unsigned NUM_REGS = 3;
  localparam int unsigned SAT_IDX  = NUM_REGS - 1;
  localparam int unsigned SLOTS    = 1 << PTR_W;

  typedef logic [PTR_W-1:0] ptr_t;

  typedef enum logic [PTR_W-1:0] {
    PTR_IE   = 2'd0,
    PTR_CTRL = 2'd1,
    PTR_STAT = 2'd2,
    PTR_BAD  = 2'd3
  } ptr_e;

  // saturating step; invalid slot stays put
  function automatic ptr_t ptr_step(ptr_t p);
    return (p < ptr_t'(SAT_IDX)) ? p + ptr_t'(1) : p;
  endfunction

  function automatic logic ptr_writable(ptr_t p);
    return p < ptr_t'(SAT_IDX);
  endfunction
endpackage

// File: rtl/regacc_ptr.sv
module regacc_ptr
  import regacc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AI_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_vld_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  output ptr_t              ptr_o,
  output logic              cmd_phase_o
);
  ptr_t ptr_q;
  logic ai_q;
  logic cmd_q;
  logic cmd_take;
  logic data_byte;

  assign cmd_take  = wr_vld_i && cmd_q && !start_i;
  assign data_byte = !start_i && ((wr_vld_i && !cmd_q) || rd_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= ptr_t'(PTR_IE);
      ai_q  <= 1'b0;
      cmd_q <= 1'b1;
    end else if (start_i) begin
      cmd_q <= 1'b1;
    end else if (cmd_take) begin
      ptr_q <= wr_data_i[PTR_W-1:0];
      ai_q  <= wr_data_i[AI_BIT];
      cmd_q <= 1'b0;
    end else if (data_byte && ai_q) begin
      ptr_q <= ptr_step(ptr_q);
    end
  end

  assign ptr_o       = ptr_q;
  assign cmd_phase_o = cmd_q;

  assert_ptr_saturate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_byte && ptr_q == ptr_t'(PTR_STAT)) |=> ptr_q == ptr_t'(PTR_STAT));
  assert_ptr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_byte && !ai_q) |=> $stable(ptr_q));
  assert_bad_stays_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_byte && ptr_q == ptr_t'(PTR_BAD)) |=> ptr_q == ptr_t'(PTR_BAD));
  assert_restart_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cmd_q);
endmodule

// File: rtl/regacc_wr.sv
module regacc_wr
  import regacc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_vld_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cmd_phase_i,
  input  ptr_t              ptr_i,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic              ie_we_o,
  output logic              ctrl_we_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic byte_in;
  logic is_data;
  logic ok;

  assign byte_in = wr_vld_i && !start_i;
  assign is_data = byte_in && !cmd_phase_i;
  assign ok      = cmd_phase_i || ptr_writable(ptr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_vld_o <= 1'b0;
      ack_o     <= 1'b0;
      ie_we_o   <= 1'b0;
      ctrl_we_o <= 1'b0;
      wdata_o   <= '0;
    end else begin
      ack_vld_o <= byte_in;
      ack_o     <= byte_in && ok;
      ie_we_o   <= is_data && ptr_i == ptr_t'(PTR_IE);
      ctrl_we_o <= is_data && ptr_i == ptr_t'(PTR_CTRL);
      if (byte_in) wdata_o <= wr_data_i;
    end
  end

  assert_cmd_acked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_in && cmd_phase_i) |=> (ack_vld_o && ack_o && !ie_we_o && !ctrl_we_o));
  assert_we_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ie_we_o, ctrl_we_o}));
  assert_we_needs_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_we_o || ctrl_we_o) |-> (ack_vld_o && ack_o));
  assert_stat_refused_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_data && ptr_i == ptr_t'(PTR_STAT)) |=> (ack_vld_o && !ack_o && !ie_we_o && !ctrl_we_o));
  assert_bad_refused_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_data && ptr_i == ptr_t'(PTR_BAD)) |=> (ack_vld_o && !ack_o));
endmodule

// File: rtl/regacc_rd.sv
module regacc_rd
  import regacc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_req_i,
  input  ptr_t              ptr_i,
  input  logic [DATA_W-1:0] ie_q_i,
  input  logic [DATA_W-1:0] ctrl_q_i,
  input  logic [DATA_W-1:0] stat_q_i,
  output logic              rd_vld_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] src;
  logic [SLOTS-1:0][DATA_W-1:0]    tbl;
  logic                            take;

  assign src  = {stat_q_i, ctrl_q_i, ie_q_i};
  assign take = rd_req_i && !start_i;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_REGS) begin : g_reg
      assign tbl[g] = src[g];
    end else begin : g_void
      assign tbl[g] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o  <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_vld_o <= take;
      if (take) rd_data_o <= tbl[ptr_i];
    end
  end

  assert_rd_ie_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && ptr_i == ptr_t'(PTR_IE)) |=> (rd_vld_o && rd_data_o == $past(ie_q_i)));
  assert_rd_stat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && ptr_i == ptr_t'(PTR_STAT)) |=> (rd_data_o == $past(stat_q_i)));
  assert_rd_bad_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && ptr_i == ptr_t'(PTR_BAD)) |=> (rd_data_o == '0));
endmodule

// File: rtl/regacc_core.sv
module regacc_core
  import regacc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AI_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_vld_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  input  logic [DATA_W-1:0] ie_q_i,
  input  logic [DATA_W-1:0] ctrl_q_i,
  input  logic [DATA_W-1:0] stat_q_i,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic              ie_we_o,
  output logic              ctrl_we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_vld_o,
  output logic [DATA_W-1:0] rd_data_o
);
  ptr_t ptr;
  logic cmd_phase;

  regacc_ptr #(.DATA_W(DATA_W), .AI_BIT(AI_BIT)) u_ptr (
    .clk_i, .rst_ni, .start_i, .wr_vld_i, .wr_data_i, .rd_req_i,
    .ptr_o(ptr), .cmd_phase_o(cmd_phase)
  );

  regacc_wr #(.DATA_W(DATA_W)) u_wr (
    .clk_i, .rst_ni, .start_i, .wr_vld_i, .wr_data_i,
    .cmd_phase_i(cmd_phase), .ptr_i(ptr),
    .ack_vld_o, .ack_o, .ie_we_o, .ctrl_we_o, .wdata_o
  );

  regacc_rd #(.DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni, .start_i, .rd_req_i, .ptr_i(ptr),
    .ie_q_i, .ctrl_q_i, .stat_q_i, .rd_vld_o, .rd_data_o
  );

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_vld_i && !rd_req_i) |=> (!ack_vld_o && !ie_we_o && !ctrl_we_o && !rd_vld_o));
endmodule

// File: tb/regacc_core_bench.sv
`timescale 1ns/1ps
module regacc_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, wr_vld = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ie_q = 8'hA5, ctrl_q = 8'h3C, stat_q = 8'h5A;
  logic       ack_vld, ack, ie_we, ctrl_we, rd_vld;
  logic [7:0] wdata, rd_data;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  regacc_core u_regacc_core (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_vld_i(wr_vld),
    .wr_data_i(wr_data), .rd_req_i(rd_req), .ie_q_i(ie_q), .ctrl_q_i(ctrl_q),
    .stat_q_i(stat_q), .ack_vld_o(ack_vld), .ack_o(ack), .ie_we_o(ie_we),
    .ctrl_we_o(ctrl_we), .wdata_o(wdata), .rd_vld_o(rd_vld), .rd_data_o(rd_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // result packed as {ack_vld, ack, ie_we, ctrl_we, wdata}
  task automatic wr_byte(input logic [7:0] d, output logic [11:0] r);
    @(negedge clk) begin wr_vld = 1'b1; wr_data = d; end
    @(negedge clk) begin
      wr_vld = 1'b0;
      r = {ack_vld, ack, ie_we, ctrl_we, wdata};
    end
  endtask

  task automatic rd_byte(output logic [8:0] r);
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) begin
      rd_req = 1'b0;
      r = {rd_vld, rd_data};
    end
  endtask

  task automatic t_reset();
    logic [8:0] r;
    chk("R1 strobes low", {28'd0, ack_vld, ie_we, ctrl_we, rd_vld}, 32'd0);
    rd_byte(r);
    chk("R1 read ie before cmd", {23'd0, r}, {23'd0, 1'b1, 8'hA5});
  endtask

  task automatic t_cmd();
    logic [11:0] r;
    do_start();
    wr_byte(8'h01, r);
    chk("R2 cmd acked no we", {20'd0, r[11:8]}, 32'h0000_000C);
  endtask

  task automatic t_write_ie();
    logic [11:0] r;
    do_start();
    wr_byte(8'h00, r);
    wr_byte(8'h11, r);
    chk("R4 ie write", {20'd0, r}, {20'd0, 4'b1110, 8'h11});
    wr_byte(8'h22, r);
    chk("R7 ie write again no ai", {20'd0, r}, {20'd0, 4'b1110, 8'h22});
  endtask

  task automatic t_write_ctrl();
    logic [11:0] r;
    do_start();
    wr_byte(8'h01, r);
    wr_byte(8'h33, r);
    chk("R4 ctrl write", {20'd0, r}, {20'd0, 4'b1101, 8'h33});
  endtask

  task automatic t_stat_write();
    logic [11:0] r;
    do_start();
    wr_byte(8'h02, r);
    wr_byte(8'h77, r);
    chk("R5 status write refused", {20'd0, r[11:8]}, 32'h0000_0008);
  endtask

  task automatic t_ai_burst();
    logic [11:0] r;
    do_start();
    wr_byte(8'h04, r);
    wr_byte(8'h81, r);
    chk("R6 ai byte1 ie", {20'd0, r}, {20'd0, 4'b1110, 8'h81});
    wr_byte(8'h82, r);
    chk("R6 ai byte2 ctrl", {20'd0, r}, {20'd0, 4'b1101, 8'h82});
    wr_byte(8'h83, r);
    chk("R6 ai byte3 refused", {20'd0, r[11:8]}, 32'h0000_0008);
    wr_byte(8'h84, r);
    chk("R6 ai saturated refused", {20'd0, r[11:8]}, 32'h0000_0008);
  endtask

  task automatic t_ai_read();
    logic [11:0] w;
    logic [8:0]  r;
    do_start();
    wr_byte(8'h04, w);
    do_start();
    rd_byte(r);
    chk("R10 ai read ie", {23'd0, r}, {23'd0, 1'b1, 8'hA5});
    rd_byte(r);
    chk("R10 ai read ctrl", {23'd0, r}, {23'd0, 1'b1, 8'h3C});
    rd_byte(r);
    chk("R3 ai read stat", {23'd0, r}, {23'd0, 1'b1, 8'h5A});
    rd_byte(r);
    chk("R6 ai read no wrap", {23'd0, r}, {23'd0, 1'b1, 8'h5A});
  endtask

  task automatic t_read_noai();
    logic [11:0] w;
    logic [8:0]  r;
    do_start();
    wr_byte(8'h01, w);
    rd_byte(r);
    chk("R3 read ctrl", {23'd0, r}, {23'd0, 1'b1, 8'h3C});
    rd_byte(r);
    chk("R7 read ctrl again", {23'd0, r}, {23'd0, 1'b1, 8'h3C});
  endtask

  task automatic t_bad();
    logic [11:0] w;
    logic [8:0]  r;
    do_start();
    wr_byte(8'h03, w);
    wr_byte(8'hEE, w);
    chk("R8 bad write refused", {20'd0, w[11:8]}, 32'h0000_0008);
    do_start();
    wr_byte(8'h07, w);
    rd_byte(r);
    chk("R8 bad read zero", {23'd0, r}, {23'd0, 1'b1, 8'h00});
    rd_byte(r);
    chk("R8 bad stays under ai", {23'd0, r}, {23'd0, 1'b1, 8'h00});
  endtask

  task automatic t_restart();
    logic [11:0] w;
    do_start();
    wr_byte(8'h01, w);
    do_start();
    wr_byte(8'h00, w);
    chk("R9 byte after restart is cmd", {20'd0, w[11:8]}, 32'h0000_000C);
    wr_byte(8'h44, w);
    chk("R9 new pointer used", {20'd0, w}, {20'd0, 4'b1110, 8'h44});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd();
    t_write_ie();
    t_write_ctrl();
    t_stat_write();
    t_ai_burst();
    t_ai_read();
    t_read_noai();
    t_bad();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule